// File: doc/BRIEF.md
# Double-Buffered SPI Transmit Path

This block is the transmit half of an SPI master. A producer, either a processor or a DMA engine, writes 32-bit command words. The upper half of each word carries control: which chip-select line to drive, and whether to keep it driven after the word ends. The lower half carries a 16-bit payload, which is shifted out most significant bit first on a serial clock derived from the system clock by a programmable divider.

The path holds at most two words: one in the shift register and one in a single holding buffer in front of it. A write that finds both stages empty goes straight into the shift register. A write that finds the shifter busy is parked in the holding buffer. When the shifter finishes a word, the parked word moves into it on the same clock edge, and the block raises a one-cycle transfer request so the producer can supply the next word. The request also fires after a direct load, and once when transmission is enabled with both stages empty. A producer that answers each request with one write therefore never loses data. A write that lands on an already full buffer replaces the parked word, and a sticky overwrite flag records the loss.

Top module: `spi_tx_dbuf`

## Requirements
- R1: After reset, `sclk` and `mosi` are low, every `cs_n` line is high, and `dma_req` and `ovr_flag` are low.
- R2: With `tx_en` high and both stages empty, a write starts shifting at once. The payload `wr_data[15:0]` appears on `mosi` MSB first. Each bit is valid at the rising edge of `sclk`, and `sclk` idles low while the shifter is empty.
- R3: Each high and each low phase of `sclk` lasts `div_cfg + 1` system clock cycles. A word produces exactly 16 rising edges.
- R4: A write arriving while the shifter is busy and the buffer is empty is held. It is sent right after the current word, with no loss and in write order.
- R5: `dma_req` is a single-cycle pulse. It fires on each buffer-to-shifter transfer, on each direct load, and when `tx_en` rises with both stages empty. A producer answering every pulse with one write of N words sees N+1 pulses.
- R6: A write while the buffer is full, and no transfer takes place in that cycle, replaces the buffered word. The replaced word is never sent, and `ovr_flag` sets and stays set.
- R7: A pulse on `ovr_clr` clears `ovr_flag`.
- R8: `wr_data[17:16]` selects line `cs_n[sel]`, which is driven low while that word shifts and all other lines stay high. If `wr_data[28]` is 1, the line stays low after the word until the next word loads. If it is 0 and no word follows, all lines return high.
- R9: While `tx_en` is low, nothing is shifted and a write is only buffered. When `tx_en` rises, the buffered word moves to the shifter, with one request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| div_cfg | input | DIV_W | Serial clock half-period minus one, in system clock cycles |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 32 | Command word: control in 31:16, payload in 15:0 |
| ovr_clr | input | 1 | Write-one-to-clear for the overwrite flag |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 2**CS_W | Active-low chip selects |
| dma_req | output | 1 | One-cycle transfer request |
| ovr_flag | output | 1 | Sticky overwrite indication |

## Verification
A wrong buffer or occupancy state shows up on the serial line within one word time. A lost, duplicated or reordered payload appears in the deserialized stream, and a missing or extra `dma_req` pulse stalls or floods the answering producer, so the pulse count per stream is off by one. A wrong divider or bit counter state shows in the next `sclk` phase as a wrong cycle count, or in the next word as a wrong bit total. A chip-select state error is visible on `cs_n` in the cycle after a load, and again at word end.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
  localparam int CMD_W    = 32;
  localparam int PAY_W    = 16;
  localparam int SEL_LSB  = 16;
  localparam int HOLD_BIT = 28;
endpackage

// File: rtl/spi_tx_clkdiv.sv
module spi_tx_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int PAY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAY_W-1:0] load_data,
  input  logic             tick,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi
);
  localparam int CNT_W = (PAY_W > 1) ? $clog2(PAY_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAY_W - 1);

  logic [PAY_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic             sclk_q, sclk_d;
  logic             busy_q, busy_d;

  assign done = busy_q && tick && sclk_q && (bcnt_q == LAST);
  assign busy = busy_q;
  assign sclk = sclk_q;
  assign mosi = sreg_q[PAY_W-1];

  always_comb begin
    sreg_d = sreg_q;
    bcnt_d = bcnt_q;
    sclk_d = sclk_q;
    busy_d = busy_q;
    if (load) begin
      sreg_d = load_data;
      bcnt_d = '0;
      sclk_d = 1'b0;
      busy_d = 1'b1;
    end else if (busy_q && tick) begin
      if (!sclk_q) begin
        sclk_d = 1'b1;
      end else begin
        sclk_d = 1'b0;
        sreg_d = {sreg_q[PAY_W-2:0], 1'b0};
        bcnt_d = bcnt_q + 1'b1;
        if (bcnt_q == LAST) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      bcnt_q <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      bcnt_q <= bcnt_d;
      sclk_q <= sclk_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_word,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] word,
  output logic         ovr_evt
);
  logic         full_q, full_d;
  logic [W-1:0] word_q, word_d;

  assign full    = full_q;
  assign word    = word_q;
  assign ovr_evt = wr && full_q && !take;

  always_comb begin
    full_d = full_q;
    word_d = word_q;
    if (wr) begin
      full_d = 1'b1;
      word_d = wr_word;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else begin
      full_q <= full_d;
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/spi_tx_dbuf.sv
module spi_tx_dbuf
  import spi_tx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CS_W  = 2,
  localparam int CS_NUM = 1 << CS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic              wr_en,
  input  logic [CMD_W-1:0]  wr_data,
  input  logic              ovr_clr,
  output logic              sclk,
  output logic              mosi,
  output logic [CS_NUM-1:0] cs_n,
  output logic              dma_req,
  output logic              ovr_flag
);
  localparam int ENT_W = PAY_W + CS_W + 1;

  logic [ENT_W-1:0] wr_ent, hb_word, sh_ent;
  logic             hb_full, hb_wr, ovr_evt;
  logic             sh_busy, sh_done, sh_load, tick;
  logic             load_direct, handoff, en_rise;
  logic             tx_en_q, req_q, req_d, ovr_q, ovr_d;
  logic [CS_W-1:0]  sel_q, sel_d;
  logic             hold_q, hold_d, keep_q, keep_d;
  logic             unused_ctrl;

  assign wr_ent = {wr_data[HOLD_BIT], wr_data[SEL_LSB +: CS_W], wr_data[PAY_W-1:0]};
  assign unused_ctrl = ^{wr_data[CMD_W-1:HOLD_BIT+1], wr_data[HOLD_BIT-1:SEL_LSB+CS_W]};

  assign load_direct = wr_en && tx_en && !sh_busy && !hb_full;
  assign handoff     = tx_en && hb_full && (!sh_busy || sh_done);
  assign en_rise     = tx_en && !tx_en_q && !sh_busy && !hb_full;
  assign sh_load     = load_direct || handoff;
  assign hb_wr       = wr_en && !load_direct;
  assign sh_ent      = load_direct ? wr_ent : hb_word;

  spi_tx_hold #(.W(ENT_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .wr(hb_wr), .wr_word(wr_ent), .take(handoff),
    .full(hb_full), .word(hb_word), .ovr_evt(ovr_evt)
  );

  spi_tx_clkdiv #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .run(sh_busy), .div(div_cfg), .tick(tick)
  );

  spi_tx_shift #(.PAY_W(PAY_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_data(sh_ent[PAY_W-1:0]),
    .tick(tick), .busy(sh_busy), .done(sh_done), .sclk(sclk), .mosi(mosi)
  );

  always_comb begin
    req_d  = handoff || load_direct || en_rise;
    ovr_d  = ovr_evt ? 1'b1 : (ovr_clr ? 1'b0 : ovr_q);
    sel_d  = sel_q;
    hold_d = hold_q;
    keep_d = keep_q;
    if (sh_load) begin
      sel_d  = sh_ent[PAY_W +: CS_W];
      hold_d = sh_ent[ENT_W-1];
      keep_d = 1'b0;
    end else if (sh_done) begin
      keep_d = hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      req_q   <= 1'b0;
      ovr_q   <= 1'b0;
      sel_q   <= '0;
      hold_q  <= 1'b0;
      keep_q  <= 1'b0;
    end else begin
      tx_en_q <= tx_en;
      req_q   <= req_d;
      ovr_q   <= ovr_d;
      sel_q   <= sel_d;
      hold_q  <= hold_d;
      keep_q  <= keep_d;
    end
  end

  for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
    assign cs_n[i] = !((sh_busy || keep_q) && (sel_q == CS_W'(i)));
  end

  assign dma_req  = req_q;
  assign ovr_flag = ovr_q;
endmodule

// File: rtl/spi_tx_dbuf_chk.sv
module spi_tx_dbuf_chk #(
  parameter int CS_NUM = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              ovr_clr,
  input logic              sclk,
  input logic [CS_NUM-1:0] cs_n,
  input logic              dma_req,
  input logic              ovr_flag,
  input logic              busy,
  input logic              hb_full
);
  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);
  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);
  // R6
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(hb_full));
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R8
  cs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(~cs_n) == 1));
  // R9
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> !busy);
endmodule

bind spi_tx_dbuf spi_tx_dbuf_chk #(.CS_NUM(CS_NUM)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ovr_clr(ovr_clr), .sclk(sclk),
  .cs_n(cs_n), .dma_req(dma_req), .ovr_flag(ovr_flag), .busy(sh_busy),
  .hb_full(hb_full)
);

// File: tb/spi_tx_dbuf_tb.sv
module spi_tx_dbuf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic [7:0]  div_cfg = 8'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic        ovr_clr = 1'b0;
  logic        sclk, mosi, dma_req, ovr_flag;
  logic [3:0]  cs_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int req_cnt = 0;
  int rx_n = 0;
  int bits = 0;
  int hp_bad = 0;
  int last_rise = 0;
  int cur_div = 0;
  logic        sclk_prev = 1'b0;
  logic [15:0] shreg = '0;
  logic [15:0] rx [0:63];

  always #10 clk = ~clk;

  spi_tx_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .div_cfg(div_cfg), .wr_en(wr_en),
    .wr_data(wr_data), .ovr_clr(ovr_clr), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .dma_req(dma_req), .ovr_flag(ovr_flag)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (dma_req) req_cnt++;
      if (sclk && !sclk_prev) begin
        shreg = {shreg[14:0], mosi};
        bits++;
        last_rise = cyc;
        if (bits == 16) begin
          if (rx_n < 64) rx[rx_n] = shreg;
          rx_n++;
          bits = 0;
        end
      end
      if (!sclk && sclk_prev && (cyc - last_rise != cur_div + 1)) hp_bad++;
      sclk_prev = sclk;
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  function automatic logic [31:0] mk(input bit hold, input logic [1:0] sel, input logic [15:0] d);
    return {3'b000, hold, 10'b0, sel, d};
  endfunction

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rx(input int target);
    int t = 0;
    while (rx_n < target && t < 20000) begin
      @(posedge clk);
      t++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int divs [5] = '{0, 1, 2, 5, 30};
    int base, rbase, seen;
    logic [15:0] d;

    idle(3);
    #1;
    // R1: reset values
    chk(sclk == 1'b0 && mosi == 1'b0, "R1 sclk/mosi", {sclk, mosi}, 0);
    chk(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
    chk(dma_req == 1'b0 && ovr_flag == 1'b0, "R1 req/ovr", {dma_req, ovr_flag}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R5: producer-paced streams over several divider settings
    foreach (divs[k]) begin
      @(negedge clk);
      div_cfg = 8'(divs[k]);
      cur_div = divs[k];
      base = rx_n;
      rbase = req_cnt;
      hp_bad = 0;
      seen = req_cnt;
      @(negedge clk);
      tx_en = 1'b1;
      for (int i = 0; i < 4; i++) begin
        while (req_cnt == seen) @(posedge clk);
        seen = req_cnt;
        d = 16'h8000 ^ 16'(i * 16'h1357) ^ {8'h00, 8'(divs[k])};
        write_word(mk(1'b0, 2'(i), d));
      end
      wait_rx(base + 4);
      idle(4 * (cur_div + 1));
      #1;
      chk(rx_n == base + 4 && bits == 0, "R3 word/bit count", rx_n - base, 4);
      for (int i = 0; i < 4; i++) begin
        d = 16'h8000 ^ 16'(i * 16'h1357) ^ {8'h00, 8'(divs[k])};
        chk(rx[base + i] == d, "R2 R4 payload order", rx[base + i], d);
      end
      chk(hp_bad == 0, "R3 sclk phase length", hp_bad, 0);
      chk(req_cnt - rbase == 5, "R5 request count", req_cnt - rbase, 5);
      chk(cs_n == 4'hF && sclk == 1'b0, "R8 R2 idle after stream", {cs_n, sclk}, 5'h1E);
      chk(ovr_flag == 1'b0, "R6 no overwrite when paced", ovr_flag, 0);
      @(negedge clk);
      tx_en = 1'b0;
    end

    // R6 R7: overwrite of the buffered word
    @(negedge clk);
    div_cfg = 8'd3;
    cur_div = 3;
    tx_en = 1'b1;
    base = rx_n;
    idle(2);
    write_word(mk(1'b0, 2'd0, 16'h1234));
    wr_en = 1'b1; wr_data = mk(1'b0, 2'd0, 16'hBEEF);
    @(negedge clk);
    wr_data = mk(1'b0, 2'd0, 16'hC0DE);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk(ovr_flag == 1'b1, "R6 flag set", ovr_flag, 1);
    wait_rx(base + 2);
    idle(40);
    #1;
    chk(rx_n == base + 2, "R6 lost word count", rx_n - base, 2);
    chk(rx[base] == 16'h1234, "R6 first word", rx[base], 16'h1234);
    chk(rx[base + 1] == 16'hC0DE, "R6 replacing word", rx[base + 1], 16'hC0DE);
    chk(ovr_flag == 1'b1, "R6 flag sticky", ovr_flag, 1);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    #1;
    chk(ovr_flag == 1'b0, "R7 flag cleared", ovr_flag, 0);

    // R9: write while disabled is held until enable
    @(negedge clk);
    tx_en = 1'b0;
    idle(4);
    base = rx_n;
    write_word(mk(1'b0, 2'd3, 16'h5A0F));
    rbase = req_cnt;
    idle(100);
    #1;
    chk(rx_n == base && bits == 0 && sclk == 1'b0, "R9 no shifting while disabled", rx_n - base, 0);
    chk(cs_n == 4'hF, "R9 cs idle while disabled", cs_n, 4'hF);
    @(negedge clk);
    tx_en = 1'b1;
    wait_rx(base + 1);
    idle(20);
    #1;
    chk(rx[base] == 16'h5A0F, "R9 held word sent", rx[base], 16'h5A0F);
    chk(req_cnt - rbase == 1, "R9 R5 single request on enable", req_cnt - rbase, 1);

    // R8: chip select decode and hold
    base = rx_n;
    write_word(mk(1'b1, 2'd2, 16'h0F0F));
    idle(3);
    #1;
    chk(cs_n == 4'b1011, "R8 select 2 during word", cs_n, 4'b1011);
    wait_rx(base + 1);
    idle(30);
    #1;
    chk(cs_n == 4'b1011, "R8 hold keeps select", cs_n, 4'b1011);
    write_word(mk(1'b0, 2'd1, 16'hF00D));
    idle(3);
    #1;
    chk(cs_n == 4'b1101, "R8 select 1 during word", cs_n, 4'b1101);
    wait_rx(base + 2);
    idle(30);
    #1;
    chk(cs_n == 4'hF, "R8 release without hold", cs_n, 4'hF);
    chk(rx[base + 1] == 16'hF00D, "R2 payload after hold", rx[base + 1], 16'hF00D);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule